// File: doc/BRIEF.md
# Single-Cycle 8-bit Arithmetic Logic Unit with Status Byte

This block is the execution datapath of a small 8-bit RISC core. Each clock it takes one operation code, a first register operand, a second operand that comes either from a second register or from an immediate field, and the core's current status byte. It produces the 8-bit result, a write-enable that tells the register file whether to store the result, and the next status byte. All three are registered, so the results appear one clock after the operation is presented.

Each operation touches only its own subset of the flags. The interrupt-enable and transfer bits of the status byte always pass through unchanged. Compare operations compute a subtraction for the flags only and never request a write. Subtract-with-carry and compare-with-carry keep the zero flag sticky, so that multi-byte comparisons chain correctly. The register file, the instruction decoder and the interrupt flag logic stay outside the block.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered. The cycle after a clock edge with `in_valid` high, `valid_q` is 1 and `res_q`, `we_q` and `status_q` reflect that operation. The cycle after an edge with `in_valid` low, `valid_q` and `we_q` are 0 and `res_q` and `status_q` hold their previous values. Synchronous reset clears all outputs to 0.
- R2: The status byte holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. Bits 7 (I) and 6 (T) of `status_q` always equal those of `status_in`.
- R3: ADD (a+b), ADC (a+b+C), SUB (a-b) and SBC (a-b-C) write the 8-bit result and update Z, C, N, V and H. C is the carry or borrow out of bit 7, H is the carry or borrow out of bit 3, V is two's-complement overflow, N is result bit 7 and Z means the result is zero.
- R4: For SBC and CPC, Z is 1 only if Z was already 1 in `status_in` and the new result is zero.
- R5: AND, OR, XOR, ANDN (a AND NOT b, which clears bits) and TST (a AND a) write the result, update Z and N, force V to 0, and leave C and H unchanged.
- R6: INC (a+1) and DEC (a-1) update Z, N and V and leave C and H unchanged. V is 1 exactly when INC gives 0x80 or DEC gives 0x7F.
- R7: COM writes 0xFF-a and sets C=1, V=0. NEG writes 0x00-a, sets C to 1 when the result is nonzero, V to 1 when the result is 0x80, and H to the borrow out of bit 3. Both leave H (COM) or nothing else untouched beyond Z and N.
- R8: LSL fills bit 0 with 0. LSR fills bit 7 with 0. ROL fills bit 0 with the old C. ROR fills bit 7 with the old C. ASR keeps bit 7. C receives the bit shifted out, V = N XOR C, and H is unchanged.
- R9: SWAP exchanges the two nibbles and SER writes 0xFF. Both write the result and leave the whole status byte unchanged.
- R10: CP and CPC update the flags exactly as SUB and SBC do, with `res_q` carrying the difference and `we_q` held at 0.
- R11: Whenever an operation updates N or V, S is recomputed as N XOR V.
- R12: With `use_imm` at 1, `imm` replaces `b` as the second operand of every operation that uses one.
- R13: Operation codes: ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, ANDN=7, TST=8, INC=9, DEC=10, COM=11, NEG=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17, SWAP=18, SER=19, CP=20, CPC=21. Codes 22 to 31 give `we_q`=0 and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see R13) |
| a | input | 8 | First register operand |
| b | input | 8 | Second register operand |
| imm | input | 8 | Immediate operand |
| use_imm | input | 1 | Select `imm` instead of `b` |
| status_in | input | 8 | Current status byte |
| valid_q | output | 1 | Registered outputs belong to an operation |
| we_q | output | 1 | Result should be written back |
| res_q | output | 8 | Registered result |
| status_q | output | 8 | Registered next status byte |

## Verification
On every cycle the assertions check the relations that hold whatever the operand values are. The I and T bits pass through. S agrees with N and V. Compares never write. Logical, increment and decrement operations keep C and H. SWAP and SER leave the status byte unchanged. The sticky Z of SBC never appears out of a cleared Z. The actual arithmetic values can only be shown by the bench's scenarios, which compare against an integer model: carries and borrows out of bits 3 and 7, the overflow boundaries at 0x7F and 0x80, the fill bits of each shift and rotate, and immediate selection.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_ANDN = 5'd7,
    OP_TST  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_COM  = 5'd11,
    OP_NEG  = 5'd12,
    OP_LSL  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ROR  = 5'd16,
    OP_ASR  = 5'd17,
    OP_SWAP = 5'd18,
    OP_SER  = 5'd19,
    OP_CP   = 5'd20,
    OP_CPC  = 5'd21
  } alu_op_e;

  // status byte bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [1:0] {
    SRC_ARITH,
    SRC_SHIFT,
    SRC_LOGIC
  } res_src_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,   // carry for add, borrow for subtract
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out, // carry or borrow out of the top bit
  output logic          h_out, // carry or borrow out of the low half
  output logic          v_out
);
  localparam int HW = DW / 2;

  logic [DW-1:0] y_eff;
  logic          ci_eff;
  logic [DW:0]   full;
  logic [HW:0]   half;

  // subtraction as x + ~y + ~borrow
  assign y_eff  = sub ? ~y : y;
  assign ci_eff = sub ? ~cin : cin;

  assign full = {1'b0, x} + {1'b0, y_eff} + {{DW{1'b0}}, ci_eff};
  assign half = {1'b0, x[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, ci_eff};

  assign sum   = full[DW-1:0];
  assign c_out = sub ? ~full[DW] : full[DW];
  assign h_out = sub ? ~half[HW] : half[HW];
  assign v_out = (x[DW-1] == y_eff[DW-1]) && (full[DW-1] != x[DW-1]);

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] x,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          c_out
);
  logic [DW-1:0] left_v;
  logic [DW-1:0] right_v;
  logic          fill_l;
  logic          fill_r;
  logic          go_left;

  always_comb begin
    fill_l  = (op == OP_ROL) ? cin : 1'b0;
    unique case (op)
      OP_ROR:  fill_r = cin;
      OP_ASR:  fill_r = x[DW-1];
      default: fill_r = 1'b0;
    endcase
    go_left = (op == OP_LSL) || (op == OP_ROL);
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left_v[i] = fill_l;
    end else begin : g_up
      assign left_v[i] = x[i-1];
    end
    if (i == DW - 1) begin : g_hi
      assign right_v[i] = fill_r;
    end else begin : g_dn
      assign right_v[i] = x[i+1];
    end
  end

  assign res   = go_left ? left_v : right_v;
  assign c_out = go_left ? x[DW-1] : x[0];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] res
);
  localparam int HW = DW / 2;

  always_comb begin
    unique case (op)
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_XOR:  res = x ^ y;
      OP_ANDN: res = x & ~y;
      OP_TST:  res = x;
      OP_COM:  res = ~x;
      OP_SWAP: res = {x[HW-1:0], x[DW-1:HW]};
      OP_SER:  res = '1;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [7:0]    status_in,
  input  logic [DW-1:0] res,
  input  logic          ar_c,
  input  logic          ar_h,
  input  logic          ar_v,
  input  logic          sh_c,
  output logic [7:0]    status_nxt,
  output logic          we_nxt
);
  logic z;
  logic n;

  assign z = (res == '0);
  assign n = res[DW-1];

  always_comb begin
    status_nxt = status_in;
    we_nxt     = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        status_nxt[FL_C] = ar_c;
        status_nxt[FL_H] = ar_h;
        status_nxt[FL_V] = ar_v;
        status_nxt[FL_N] = n;
        status_nxt[FL_Z] = (op == OP_SBC || op == OP_CPC) ? (status_in[FL_Z] & z) : z;
        status_nxt[FL_S] = n ^ ar_v;
        we_nxt           = !(op == OP_CP || op == OP_CPC);
      end
      OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_TST: begin
        status_nxt[FL_V] = 1'b0;
        status_nxt[FL_N] = n;
        status_nxt[FL_Z] = z;
        status_nxt[FL_S] = n;
      end
      OP_INC, OP_DEC: begin
        status_nxt[FL_V] = ar_v;
        status_nxt[FL_N] = n;
        status_nxt[FL_Z] = z;
        status_nxt[FL_S] = n ^ ar_v;
      end
      OP_COM: begin
        status_nxt[FL_C] = 1'b1;
        status_nxt[FL_V] = 1'b0;
        status_nxt[FL_N] = n;
        status_nxt[FL_Z] = z;
        status_nxt[FL_S] = n;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        status_nxt[FL_C] = sh_c;
        status_nxt[FL_V] = n ^ sh_c;
        status_nxt[FL_N] = n;
        status_nxt[FL_Z] = z;
        status_nxt[FL_S] = sh_c;  // n ^ (n ^ c)
      end
      OP_SWAP, OP_SER: begin
        we_nxt = 1'b1;
      end
      default: begin
        we_nxt = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  imm,
  input  logic           use_imm,
  input  logic [7:0]     status_in,
  output logic           valid_q,
  output logic           we_q,
  output logic [DW-1:0]  res_q,
  output logic [7:0]     status_q
);
  alu_op_e       op_e;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] ar_x, ar_y, ar_sum;
  logic          ar_cin, ar_sub, ar_c, ar_h, ar_v;
  logic [DW-1:0] sh_res, lg_res, res_nxt;
  logic          sh_c;
  logic [7:0]    status_nxt;
  logic          we_nxt;
  res_src_e      src;

  assign op_e   = alu_op_e'(op);
  assign opnd_b = use_imm ? imm : b;

  // operand steering for the shared adder
  always_comb begin
    ar_x   = a;
    ar_y   = opnd_b;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    src    = SRC_LOGIC;
    unique case (op_e)
      OP_ADD: src = SRC_ARITH;
      OP_ADC: begin src = SRC_ARITH; ar_cin = status_in[FL_C]; end
      OP_SUB, OP_CP: begin src = SRC_ARITH; ar_sub = 1'b1; end
      OP_SBC, OP_CPC: begin
        src    = SRC_ARITH;
        ar_sub = 1'b1;
        ar_cin = status_in[FL_C];
      end
      OP_INC: begin src = SRC_ARITH; ar_y = '0; ar_cin = 1'b1; end
      OP_DEC: begin src = SRC_ARITH; ar_y = '0; ar_cin = 1'b1; ar_sub = 1'b1; end
      OP_NEG: begin src = SRC_ARITH; ar_x = '0; ar_y = a; ar_sub = 1'b1; end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: src = SRC_SHIFT;
      default: src = SRC_LOGIC;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x(ar_x), .y(ar_y), .cin(ar_cin), .sub(ar_sub),
    .sum(ar_sum), .c_out(ar_c), .h_out(ar_h), .v_out(ar_v)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op(op_e), .x(a), .cin(status_in[FL_C]), .res(sh_res), .c_out(sh_c)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(op_e), .x(a), .y(opnd_b), .res(lg_res)
  );

  always_comb begin
    unique case (src)
      SRC_ARITH: res_nxt = ar_sum;
      SRC_SHIFT: res_nxt = sh_res;
      default:   res_nxt = lg_res;
    endcase
  end

  alu8_flags #(.DW(DW)) u_flags (
    .op(op_e), .status_in(status_in), .res(res_nxt),
    .ar_c(ar_c), .ar_h(ar_h), .ar_v(ar_v), .sh_c(sh_c),
    .status_nxt(status_nxt), .we_nxt(we_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      we_q     <= 1'b0;
      res_q    <= '0;
      status_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        we_q     <= we_nxt;
        res_q    <= res_nxt;
        status_q <= status_nxt;
      end else begin
        we_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [OPW-1:0] op,
  input logic [7:0]     status_in,
  input logic           valid_q,
  input logic           we_q,
  input logic [DW-1:0]  res_q,
  input logic [7:0]     status_q
);
  logic is_logic, is_shift, is_incdec, is_keep, is_addsub;

  assign is_logic  = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                     (op == OP_ANDN) || (op == OP_TST);
  assign is_shift  = (op == OP_LSL) || (op == OP_LSR) || (op == OP_ROL) ||
                     (op == OP_ROR) || (op == OP_ASR);
  assign is_incdec = (op == OP_INC) || (op == OP_DEC);
  assign is_keep   = (op == OP_SWAP) || (op == OP_SER);
  assign is_addsub = (op == OP_ADD) || (op == OP_SUB);

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !valid_q && !we_q); // R1

  AST_IT_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> status_q[FL_I:FL_T] == $past(status_in[FL_I:FL_T])); // R2

  AST_ADDSUB_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_addsub |=> status_q[FL_Z] == (res_q == '0)); // R3

  AST_SBC_Z_STICKY: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == OP_SBC || op == OP_CPC) && !status_in[FL_Z] |=> !status_q[FL_Z]); // R4

  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_logic |=> !status_q[FL_V] &&
      status_q[FL_C] == $past(status_in[FL_C]) && status_q[FL_H] == $past(status_in[FL_H])); // R5

  AST_INCDEC_KEEP_CH: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_incdec |=> status_q[FL_C] == $past(status_in[FL_C]) &&
      status_q[FL_H] == $past(status_in[FL_H])); // R6

  AST_COM_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == OP_COM |=> status_q[FL_C] && !status_q[FL_V]); // R7

  AST_SHIFT_V: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_shift |=> status_q[FL_V] == (status_q[FL_N] ^ status_q[FL_C])); // R8

  AST_KEEP_STATUS: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_keep |=> status_q == $past(status_in) && we_q); // R9

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == OP_CP || op == OP_CPC) |=> valid_q && !we_q); // R10

  AST_S_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_keep && op <= OP_CPC |=>
      status_q[FL_S] == (status_q[FL_N] ^ status_q[FL_V])); // R11

endmodule

bind alu8_core alu8_chk #(.DW(DW)) u_alu8_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .status_in(status_in),
  .valid_q(valid_q), .we_q(we_q), .res_q(res_q), .status_q(status_q)
);

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [4:0] op;
  logic [7:0] a, b, imm, status_in;
  logic       use_imm;
  logic       valid_q, we_q;
  logic [7:0] res_q, status_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .imm(imm), .use_imm(use_imm), .status_in(status_in),
    .valid_q(valid_q), .we_q(we_q), .res_q(res_q), .status_q(status_q)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(input int o, input bit im);
    if (im && (o <= 7 || o >= 20) && o <= 21) return "R12";
    case (o)
      0, 1, 2: return "R3";
      3:       return "R4";
      4, 5, 6, 7, 8: return "R5";
      9, 10:   return "R6";
      11, 12:  return "R7";
      13, 14, 15, 16, 17: return "R8";
      18, 19:  return "R9";
      20, 21:  return "R10";
      default: return "R13";
    endcase
  endfunction

  // integer reference model built from the requirements
  function automatic void model(input int o, input int av, input int bv,
                                input logic [7:0] si, output bit ewe,
                                output int er, output logic [7:0] es,
                                output bit chk_res);
    int r, sr, ci;
    bit c, h, v;
    ewe = 1; chk_res = 1; es = si; r = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(si[0]) : 0;
        r  = av + bv + ci;
        c  = r > 255;
        h  = ((av & 15) + (bv & 15) + ci) > 15;
        sr = sgn(av) + sgn(bv) + ci;
        v  = (sr > 127) || (sr < -128);
        r  = r & 255;
        es[0] = c; es[5] = h; es[3] = v; es[2] = r[7]; es[1] = (r == 0);
        es[4] = r[7] ^ v;
      end
      2, 3, 20, 21: begin
        ci = (o == 3 || o == 21) ? int'(si[0]) : 0;
        r  = av - bv - ci;
        c  = r < 0;
        h  = ((av & 15) - (bv & 15) - ci) < 0;
        sr = sgn(av) - sgn(bv) - ci;
        v  = (sr > 127) || (sr < -128);
        r  = r & 255;
        es[0] = c; es[5] = h; es[3] = v; es[2] = r[7];
        es[1] = (o == 3 || o == 21) ? (si[1] && r == 0) : (r == 0);
        es[4] = r[7] ^ v;
        ewe = !(o == 20 || o == 21);
      end
      4, 5, 6, 7, 8: begin
        case (o)
          4: r = av & bv;
          5: r = av | bv;
          6: r = av ^ bv;
          7: r = av & (~bv & 255);
          default: r = av;
        endcase
        es[3] = 0; es[2] = r[7]; es[1] = (r == 0); es[4] = r[7];
      end
      9, 10: begin
        r = (o == 9) ? (av + 1) & 255 : (av + 255) & 255;
        v = (o == 9) ? (r == 128) : (r == 127);
        es[3] = v; es[2] = r[7]; es[1] = (r == 0); es[4] = r[7] ^ v;
      end
      11: begin
        r = 255 - av;
        es[0] = 1; es[3] = 0; es[2] = r[7]; es[1] = (r == 0); es[4] = r[7];
      end
      12: begin
        r = (256 - av) & 255;
        v = (r == 128);
        es[0] = (r != 0); es[3] = v; es[5] = ((av & 15) != 0);
        es[2] = r[7]; es[1] = (r == 0); es[4] = r[7] ^ v;
      end
      13, 14, 15, 16, 17: begin
        case (o)
          13: begin r = (av << 1) & 255; c = av[7]; end
          14: begin r = av >> 1; c = av[0]; end
          15: begin r = ((av << 1) | int'(si[0])) & 255; c = av[7]; end
          16: begin r = (av >> 1) | (int'(si[0]) << 7); c = av[0]; end
          default: begin r = (av >> 1) | (av & 128); c = av[0]; end
        endcase
        v = r[7] ^ c;
        es[0] = c; es[3] = v; es[2] = r[7]; es[1] = (r == 0); es[4] = r[7] ^ v;
      end
      18: r = ((av & 15) << 4) | (av >> 4);
      19: r = 255;
      default: begin ewe = 0; chk_res = 0; end
    endcase
    er = r;
  endfunction

  task automatic apply(input int o, input int av, input int bv, input int iv,
                       input bit im, input logic [7:0] si);
    bit ewe, cr;
    int er;
    logic [7:0] es;
    string t;
    @(negedge clk);
    in_valid = 1; op = o[4:0]; a = av[7:0]; b = bv[7:0]; imm = iv[7:0];
    use_imm = im; status_in = si;
    model(o, av, im ? iv : bv, si, ewe, er, es, cr);
    t = tag_of(o, im);
    @(negedge clk);
    check(valid_q === 1'b1, "R1", "valid_q", int'(valid_q), 1);
    check(we_q === ewe, t, $sformatf("we_q op=%0d", o), int'(we_q), int'(ewe));
    if (cr) check(res_q === er[7:0], t, $sformatf("res_q op=%0d", o), int'(res_q), er);
    check(status_q[7:6] === es[7:6], "R2", "status I/T", int'(status_q[7:6]), int'(es[7:6]));
    check(status_q[4] === es[4], "R11", $sformatf("S op=%0d", o), int'(status_q[4]), int'(es[4]));
    check({status_q[5], status_q[3:0]} === {es[5], es[3:0]}, t,
          $sformatf("flags op=%0d a=%0h b=%0h si=%0h", o, av, im ? iv : bv, si),
          int'(status_q), int'(es));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL R1 watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] hold_r, hold_s;
    void'($urandom(32'h5eed_a1f0));
    rst = 1; in_valid = 0; op = 0; a = 0; b = 0; imm = 0; use_imm = 0; status_in = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(valid_q === 1'b0 && we_q === 1'b0, "R1", "reset valid/we", int'({valid_q, we_q}), 0);
    check(res_q === 8'h00 && status_q === 8'h00, "R1", "reset res/status",
          int'({res_q, status_q}), 0);
    rst = 0;

    // directed corners
    apply(0, 8'h7F, 8'h01, 0, 0, 8'h00);  // R3 overflow and half carry
    apply(0, 8'hFF, 8'h01, 0, 0, 8'hC0);  // R3 carry, zero, I/T kept
    apply(1, 8'h0F, 8'h00, 0, 0, 8'h01);  // R3 ADC carry-in into bit 4
    apply(2, 8'h80, 8'h01, 0, 0, 8'h00);  // R3 signed overflow on subtract
    apply(2, 8'h00, 8'h01, 0, 0, 8'h00);  // R3 borrow
    apply(3, 8'h05, 8'h04, 0, 0, 8'h03);  // R4 zero with Z set stays set
    apply(3, 8'h05, 8'h04, 0, 0, 8'h01);  // R4 zero with Z clear stays clear
    apply(21, 8'h10, 8'h10, 0, 0, 8'h02); // R10 CPC zero, no write
    apply(20, 8'h10, 8'h20, 0, 0, 8'h00); // R10 CP borrow
    apply(4, 8'hF0, 8'h0F, 0, 0, 8'h29);  // R5 zero, V forced low, C/H kept
    apply(7, 8'hFF, 8'h0F, 0, 0, 8'h21);  // R5 clear bits
    apply(9, 8'h7F, 0, 0, 0, 8'h21);      // R6 INC overflow
    apply(10, 8'h80, 0, 0, 0, 8'h00);     // R6 DEC overflow
    apply(11, 8'h00, 0, 0, 0, 8'h08);     // R7 COM
    apply(12, 8'h80, 0, 0, 0, 8'h00);     // R7 NEG of 0x80
    apply(12, 8'h00, 0, 0, 0, 8'h21);     // R7 NEG of zero
    apply(15, 8'h80, 0, 0, 0, 8'h01);     // R8 ROL with carry
    apply(16, 8'h01, 0, 0, 0, 8'h01);     // R8 ROR with carry
    apply(17, 8'h81, 0, 0, 0, 8'h00);     // R8 ASR keeps sign
    apply(14, 8'h01, 0, 0, 0, 8'h00);     // R8 LSR to zero
    apply(18, 8'hA5, 0, 0, 0, 8'h3F);     // R9 swap, flags frozen
    apply(19, 8'h00, 0, 0, 0, 8'h15);     // R9 set register
    apply(0, 8'h10, 8'hEE, 8'h70, 1, 8'h00); // R12 immediate
    apply(25, 8'h10, 8'h20, 0, 0, 8'h5A); // R13 unassigned code

    // R1 idle cycle holds result and status
    @(negedge clk);
    hold_r = res_q; hold_s = status_q;
    in_valid = 0; op = 0; a = 8'hFF; b = 8'hFF; status_in = 8'hFF;
    @(negedge clk);
    check(valid_q === 1'b0 && we_q === 1'b0, "R1", "idle valid/we", int'({valid_q, we_q}), 0);
    check(res_q === hold_r && status_q === hold_s, "R1", "idle hold",
          int'({res_q, status_q}), int'({hold_r, hold_s}));

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      apply(int'($urandom_range(0, 23)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            bit'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
    end
    finish_run();
  end
endmodule